// File: doc/BRIEF.md
# Floating-point exception flag accumulator

This block sits beside a floating-point datapath and turns its per-operation status reports into sticky exception flags held in a small control/status register. Each report is a one-cycle cause vector qualified by a valid strobe. While the register's enable bit is set, every accepted report ORs its flags into the register. Software can overwrite the whole register at any time through a plain write port. A write is the only way, short of reset, to clear a flag.

After each accepted report, the block checks the flag field. If any of the eight flags is set, it issues a one-cycle exception request. In the same cycle it presents the previous-PC value that came with the report as the faulting instruction address. The status input is valid-only and has no back-pressure: the block accepts a report in every cycle, so the datapath never stalls on it. Reports that arrive while the enable bit is clear are dropped.

Top module: `fpx_flag_accum`

## Requirements
- R1: After reset the register reads 0 (enable clear, all flags clear), `exc_req` is 0 and `fault_pc` is 0.
- R2: While register bit 0 (enable, taken from the register value before any same-cycle write) is 0, a valid report changes no flag and raises no request.
- R3: Register bit 1 (invalid) is set by any of the cause bits 0 (signalling NaN), 1 (quiet NaN), 2 (inf-inf), 3 (inf/inf), 4 (0/0), 5 (inf*0), 6 (bad conversion), 7 (bad compare) and 8 (bad square root).
- R4: Cause bit 0 also sets register bit 2 (signalling-NaN flag), and cause bit 1 also sets register bit 3 (quiet-NaN flag).
- R5: Register bit 4 (infinity flag) is set only by cause bit 2 or cause bit 3.
- R6: Cause bits 9 (overflow), 10 (underflow), 11 (divide by zero) and 12 (inexact) set register bits 5, 6, 7 and 8 respectively.
- R7: Flags are sticky. With no write, a flag that is set stays set across later reports.
- R8: A write loads all 9 register bits from `csr_wr_data`. A write and an accepted report in the same cycle leave the written value ORed with the report's flags.
- R9: `exc_req` is high for exactly the one cycle after each accepted report that leaves any of register bits 8:1 set. In that cycle `fault_pc` equals the `prev_pc` given with that report, and `fault_pc` holds its value until the next request.
- R10: An accepted report that leaves all flags clear raises no request and does not change `fault_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr_en | input | 1 | Software write strobe |
| csr_wr_data | input | 9 | Value to write: bit 0 enable, bits 8:1 flags |
| st_valid | input | 1 | Status report valid (always accepted) |
| st_cause | input | 13 | Cause vector of the report |
| prev_pc | input | PC_W | Address of the instruction that produced the report |
| csr_value | output | 9 | Current register contents |
| exc_req | output | 1 | One-cycle exception request |
| fault_pc | output | PC_W | Faulting instruction address |

## Verification
Each cause bit is applied alone, with the flags cleared beforehand, so that the bench can tell which flag every cause reaches. This separates the invalid-only causes from the two that also reach the infinity flag and the two that reach the NaN flags. Reports sent with the enable bit clear, and valid reports with an empty cause vector, show the difference between a report being ignored and a report being accepted with no new flags. Accepted reports with empty causes are tried both with flags already set (a request is expected) and with all flags clear (no request is expected). Same-cycle write-and-report cases and long random mixes of sparse cause vectors with occasional writes then exercise stickiness, the OR merge on writes and back-to-back requests.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int CAUSE_W = 13;
  localparam int FLAG_W  = 8;
  localparam int CSR_W   = FLAG_W + 1;

  // cause vector bit positions
  localparam int C_SNAN  = 0;
  localparam int C_QNAN  = 1;
  localparam int C_ISI   = 2;
  localparam int C_IDI   = 3;
  localparam int C_ZDZ   = 4;
  localparam int C_IMZ   = 5;
  localparam int C_CVT   = 6;
  localparam int C_CMP   = 7;
  localparam int C_SQRT  = 8;
  localparam int C_OVF   = 9;
  localparam int C_UNF   = 10;
  localparam int C_DZ    = 11;
  localparam int C_IX    = 12;
  localparam int N_INVALID = C_SQRT + 1;

  // flag positions inside the flag field (register bit = index + 1)
  localparam int F_INV  = 0;
  localparam int F_SNAN = 1;
  localparam int F_QNAN = 2;
  localparam int F_INF  = 3;
  localparam int F_OVF  = 4;
  localparam int F_UNF  = 5;
  localparam int F_DZ   = 6;
  localparam int F_IX   = 7;

  typedef logic [CAUSE_W-1:0] cause_t;
  typedef logic [FLAG_W-1:0]  flag_t;
  typedef logic [CSR_W-1:0]   csr_t;
endpackage

// File: rtl/fpx_cause_map.sv
module fpx_cause_map
  import fpx_pkg::*;
(
  input  cause_t cause,
  output flag_t  flags
);
  logic [N_INVALID-1:0] inv_bits;

  for (genvar g = 0; g < N_INVALID; g++) begin : g_inv
    assign inv_bits[g] = cause[g];
  end

  always_comb begin
    flags         = '0;
    flags[F_INV]  = |inv_bits;
    flags[F_SNAN] = cause[C_SNAN];
    flags[F_QNAN] = cause[C_QNAN];
    flags[F_INF]  = cause[C_ISI] | cause[C_IDI];
    flags[F_OVF]  = cause[C_OVF];
    flags[F_UNF]  = cause[C_UNF];
    flags[F_DZ]   = cause[C_DZ];
    flags[F_IX]   = cause[C_IX];
  end
endmodule

// File: rtl/fpx_csr_reg.sv
module fpx_csr_reg
  import fpx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  csr_t   wr_data,
  input  logic   st_valid,
  input  flag_t  new_flags,
  output csr_t   csr_q,
  output logic   accept,
  output flag_t  flags_after
);
  csr_t base, csr_d;

  assign accept = st_valid & csr_q[0];

  always_comb begin
    base  = wr_en ? wr_data : csr_q;
    csr_d = base;
    if (accept) csr_d[CSR_W-1:1] = base[CSR_W-1:1] | new_flags;
  end

  assign flags_after = csr_d[CSR_W-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) csr_q <= '0;
    else        csr_q <= csr_d;
  end

  // R2
  flags_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_q[0] && !wr_en) |=> $stable(csr_q));

  // R7
  sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((csr_q[CSR_W-1:1] & $past(csr_q[CSR_W-1:1])) == $past(csr_q[CSR_W-1:1])));

  // R8
  write_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((csr_q & $past(wr_data)) == $past(wr_data)));
endmodule

// File: rtl/fpx_exc_gen.sv
module fpx_exc_gen
  import fpx_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  flag_t           flags_after,
  input  logic [PC_W-1:0] pc_in,
  output logic            req,
  output logic [PC_W-1:0] addr
);
  logic fire;
  assign fire = accept & (|flags_after);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req  <= 1'b0;
      addr <= '0;
    end else begin
      req <= fire;
      if (fire) addr <= pc_in;
    end
  end

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> $stable(addr));

  // R10
  req_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !(|flags_after)) |=> !req);
endmodule

// File: rtl/fpx_flag_accum.sv
module fpx_flag_accum
  import fpx_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                csr_wr_en,
  input  logic [CSR_W-1:0]    csr_wr_data,
  input  logic                st_valid,
  input  logic [CAUSE_W-1:0]  st_cause,
  input  logic [PC_W-1:0]     prev_pc,
  output logic [CSR_W-1:0]    csr_value,
  output logic                exc_req,
  output logic [PC_W-1:0]     fault_pc
);
  flag_t new_flags, flags_after;
  logic  accept;
  csr_t  csr_q;

  fpx_cause_map u_map (
    .cause (st_cause),
    .flags (new_flags)
  );

  fpx_csr_reg u_csr (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (csr_wr_en),
    .wr_data     (csr_wr_data),
    .st_valid    (st_valid),
    .new_flags   (new_flags),
    .csr_q       (csr_q),
    .accept      (accept),
    .flags_after (flags_after)
  );

  fpx_exc_gen #(.PC_W(PC_W)) u_exc (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .flags_after (flags_after),
    .pc_in       (prev_pc),
    .req         (exc_req),
    .addr        (fault_pc)
  );

  assign csr_value = csr_q;

  // R9
  req_after_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> ($past(st_valid) && $past(csr_q[0]) && (|csr_q[CSR_W-1:1])));

  // R5
  inf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(csr_q[F_INF+1]) && !$past(csr_wr_en)) |-> $past(st_cause[C_ISI] | st_cause[C_IDI]));
endmodule

// File: tb/fpx_flag_accum_tb.sv
module fpx_flag_accum_tb;
  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            csr_wr_en = 1'b0;
  logic [8:0]      csr_wr_data = '0;
  logic            st_valid = 1'b0;
  logic [12:0]     st_cause = '0;
  logic [PC_W-1:0] prev_pc = '0;
  logic [8:0]      csr_value;
  logic            exc_req;
  logic [PC_W-1:0] fault_pc;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [8:0]      exp_csr  = '0;
  logic            exp_req  = 1'b0;
  logic [PC_W-1:0] exp_addr = '0;

  always #4 clk = ~clk;

  fpx_flag_accum #(.PC_W(PC_W)) u_dut (
    .clk (clk), .rst_n (rst_n), .csr_wr_en (csr_wr_en), .csr_wr_data (csr_wr_data),
    .st_valid (st_valid), .st_cause (st_cause), .prev_pc (prev_pc),
    .csr_value (csr_value), .exc_req (exc_req), .fault_pc (fault_pc)
  );

  // flags in register bits 8:1: inv, snan, qnan, inf, ovf, unf, dz, ix
  function automatic logic [7:0] ref_flags(input logic [12:0] c);
    logic [7:0] f;
    f[0] = |c[8:0];
    f[1] = c[0];
    f[2] = c[1];
    f[3] = c[2] | c[3];
    f[4] = c[9];
    f[5] = c[10];
    f[6] = c[11];
    f[7] = c[12];
    return f;
  endfunction

  task automatic check(input string tag);
    vectors++;
    if (csr_value !== exp_csr || exc_req !== exp_req || fault_pc !== exp_addr) begin
      errors++;
      $display("FAIL %s: csr=%h req=%b pc=%h expected csr=%h req=%b pc=%h",
               tag, csr_value, exc_req, fault_pc, exp_csr, exp_req, exp_addr);
    end
  endtask

  // called at a falling edge: drive, advance model, check at next falling edge
  task automatic cyc(input logic wr, input logic [8:0] wd, input logic v,
                     input logic [12:0] c, input logic [PC_W-1:0] pc, input string tag);
    logic [8:0] nxt;
    logic       fire;
    csr_wr_en = wr; csr_wr_data = wd; st_valid = v; st_cause = c; prev_pc = pc;
    nxt = wr ? wd : exp_csr;
    if (v && exp_csr[0]) nxt[8:1] = nxt[8:1] | ref_flags(c);
    fire = v && exp_csr[0] && (|nxt[8:1]);
    @(negedge clk);
    exp_csr = nxt;
    exp_req = fire;
    if (fire) exp_addr = pc;
    check(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'h5eed_f00d);
    repeat (3) @(negedge clk);
    check("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    // R2: enable clear, reports ignored
    cyc(0, '0, 1, 13'h1fff, 32'h100, "R2 all causes disabled");
    cyc(0, '0, 1, 13'h0201, 32'h104, "R2 disabled again");
    // enable only
    cyc(1, 9'h001, 0, '0, '0, "R8 write enable");
    // each cause alone, clearing flags before
    for (int i = 0; i < 13; i++) begin
      cyc(1, 9'h001, 0, '0, '0, "R8 clear flags");
      cyc(0, '0, 1, 13'(1) << i, 32'h1000 + 32'(i) * 4,
          i < 2 ? "R4 nan cause" : (i < 4 ? "R5 inf cause" :
          (i < 9 ? "R3 invalid cause" : "R6 own flag cause")));
    end
    // R10: accepted empty report with flags clear
    cyc(1, 9'h001, 0, '0, '0, "R8 clear");
    cyc(0, '0, 1, '0, 32'hdead, "R10 empty report no request");
    // R9: empty report with flag already set still requests
    cyc(0, '0, 1, 13'h0200, 32'h2000, "R9 overflow request");
    cyc(0, '0, 1, '0, 32'h2004, "R9 empty report flags set");
    cyc(0, '0, 0, '0, 32'h2008, "R9 single pulse");
    // R7 sticky across other causes
    cyc(0, '0, 1, 13'h1000, 32'h3000, "R7 add inexact");
    cyc(0, '0, 0, '0, '0, "R7 hold");
    // R8 write and report same cycle
    cyc(1, 9'h021, 1, 13'h0800, 32'h4000, "R8 write merge");
    cyc(1, 9'h000, 1, 13'h0001, 32'h4004, "R8 disable write merge");
    cyc(0, '0, 1, 13'h0001, 32'h4008, "R2 disabled after write");
    cyc(1, 9'h000, 1, 13'h0001, 32'h400c, "R8 enable from old value");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic        wr;
      logic [8:0]  wd;
      logic        v;
      logic [12:0] c;
      wr = ($urandom % 10) == 0;
      wd = 9'($urandom);
      if (($urandom % 4) != 0) wd[0] = 1'b1;
      v  = $urandom % 2;
      c  = 13'($urandom) & 13'($urandom) & 13'($urandom);
      cyc(wr, wd, v, c, $urandom, wr ? "R8 random" : "R9 random");
    end
    finish_run();
  end
endmodule